// File: doc/BRIEF.md
# Bus Transaction Trace Encoder

This block watches the read and write strobes of a console's external bus, together with two region-select lines. It turns every completed bus transaction into one trace byte. The byte carries four things: the memory region of the transaction, which strobe was active, how many whole bus clocks the strobe was held, and a flag that is set when the strobe released halfway through a bus clock. The bytes queue in a small FIFO. A host drains the FIFO over a parallel port using a valid/read pair.

The block runs on a sample clock at twice the bus clock rate, so every sample is one half of a bus clock period. The strobes and region lines must already be synchronous to that sample clock. A transaction opens on the first sample where either active-low strobe is low. It closes on the first sample where both strobes are high again. Within that window, an odd number of active samples means the access ended mid-cycle. This is how a 2-cycle access is told apart from a 3-cycle access on the fast clock. The FIFO accepts at most one byte every two samples, because each transaction needs at least one active sample and one idle sample. That rate is well within what a host draining one byte per sample can take. When the FIFO is full, new bytes are dropped and a sticky overflow flag rises.

Top module: `bus_trace_enc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, host_valid and ovf_flag are 0.
- R2: Each transaction produces exactly one byte. host_valid rises in the cycle after the first sample in which both strobes are high again.
- R3: Bits [7:6] hold {bus_rgn[1], bus_rgn[0]} as sampled at the first active sample. Changes to bus_rgn later in the transaction are ignored. The codes mean 10 = DRAM, 00 = cartridge, 01 = CD, 11 = chip registers.
- R4: Bit 5 is 1 when bus_rd_n was low at the first active sample, and bit 4 is 1 when bus_wr_n was low at that sample.
- R5: Bit 3 (half-cycle flag) is 1 when the number of active samples is odd.
- R6: Bits [2:0] hold the number of active samples divided by two, rounded down and saturated at 7.
- R7: Bytes leave in the order the transactions ended. host_data shows the oldest byte while host_valid is 1, and host_rd removes it. host_rd while host_valid is 0 is ignored.
- R8: A byte completed while the FIFO holds 16 bytes and no read is taken is dropped. ovf_flag then goes to 1 and stays 1 until reset. The stored bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, twice the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_rgn | input | 2 | Region select lines {ROM select, high address bit} |
| host_rd | input | 1 | Host takes the byte on host_data |
| host_data | output | 8 | Oldest trace byte |
| host_valid | output | 1 | FIFO holds at least one byte |
| ovf_flag | output | 1 | Sticky: a byte was dropped |

## Verification
A wrong half-cycle parity or a bad clock counter corrupts the low nibble of the very next byte the host reads. This shows up one cycle after the strobe releases. A slipped FIFO pointer shows up as a reordered, repeated or missing byte at the next read, or as host_valid failing to drop once everything has been drained. Region or strobe latching captured at the wrong sample is exposed by changing the region lines in the middle of a transaction. A wrong full condition is caught by filling past 16 bytes: either the 17th byte appears at the port, or ovf_flag stays low.

// File: rtl/bt_pkg.sv
package bt_pkg;
   localparam int CNT_W   = 3;
   localparam int TRACE_W = 5 + CNT_W;

   typedef enum logic [1:0] {
      RG_CART = 2'b00,
      RG_CD   = 2'b01,
      RG_DRAM = 2'b10,
      RG_CHIP = 2'b11
   } region_e;

   typedef struct packed {
      region_e          region;
      logic             rd;
      logic             wr;
      logic             half;
      logic [CNT_W-1:0] clocks;
   } trace_t;
endpackage

// File: rtl/bt_strobe_track.sv
module bt_strobe_track
   import bt_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_n,
   input  logic         wr_n,
   input  logic [1:0]   rgn,
   output logic         push,
   output trace_t       trace
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic   act, act_q;
   trace_t cur;

   assign act = !rd_n || !wr_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cur   <= '0;
      end else begin
         act_q <= act;
         if (act && !act_q) begin
            cur.region <= region_e'(rgn);
            cur.rd     <= !rd_n;
            cur.wr     <= !wr_n;
            cur.half   <= 1'b1;
            cur.clocks <= '0;
         end else if (act) begin
            cur.half <= !cur.half;
            if (cur.half && cur.clocks != CNT_MAX)
               cur.clocks <= cur.clocks + 1'b1;
         end
      end
   end

   assign push  = act_q && !act;
   assign trace = cur;

   // R2: a closing edge needs at least one idle sample, so pushes never repeat back to back
   a_r2_single_push: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push);
   // R5: the parity flips on every sample of an ongoing transaction
   a_r5_half_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (act && act_q) |=> (cur.half != $past(cur.half)));
   // R6: the clock count never decreases during a transaction
   a_r6_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      (act && act_q) |=> (cur.clocks >= $past(cur.clocks)));
endmodule

// File: rtl/bt_fifo.sv
module bt_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             valid,
   output logic             ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("bt_fifo: DEPTH must be a power of two and at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("bt_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wptr, rptr, cnt;
   logic             full, empty, do_pop, do_push;

   assign cnt     = wptr - rptr;
   assign empty   = (cnt == '0);
   assign full    = (cnt == PW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         ovf  <= 1'b0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         if (push && !do_push) ovf <= 1'b1;
      end
   end

   assign rdata = mem[rptr[AW-1:0]];
   assign valid = !empty;

   // R8: occupancy never exceeds depth
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= PW'(DEPTH));
   // R8: overflow flag is sticky
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R7: a read on an empty queue leaves it empty
   a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push) |=> empty);
endmodule

// File: rtl/bus_trace_enc.sv
module bus_trace_enc
   import bt_pkg::*;
#(
   parameter int FIFO_DEPTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rd_n,
   input  logic               bus_wr_n,
   input  logic [1:0]         bus_rgn,
   input  logic               host_rd,
   output logic [TRACE_W-1:0] host_data,
   output logic               host_valid,
   output logic               ovf_flag
);
   logic   trk_push;
   trace_t trk_byte;

   bt_strobe_track i_track (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_n  (bus_rd_n),
      .wr_n  (bus_wr_n),
      .rgn   (bus_rgn),
      .push  (trk_push),
      .trace (trk_byte)
   );

   bt_fifo #(.WIDTH(TRACE_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (trk_push),
      .wdata (trk_byte),
      .pop   (host_rd),
      .rdata (host_data),
      .valid (host_valid),
      .ovf   (ovf_flag)
   );

   // R1: reset leaves the host side idle
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (!host_valid && !ovf_flag));
   // R2: a byte appears right after a transaction closes
   a_r2_valid_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      trk_push |=> host_valid);
endmodule

// File: tb/test_bus_trace_enc.sv
`timescale 1ns/1ps
module test_bus_trace_enc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rd_n = 1'b1, bus_wr_n = 1'b1;
   logic [1:0] bus_rgn = 2'b00;
   logic       mon_rd = 1'b0, tst_rd = 1'b0;
   logic       host_rd;
   logic [7:0] host_data;
   logic       host_valid, ovf_flag;

   int  n_cmp = 0, n_bad = 0;
   bit  drain = 1'b0;
   bit  done  = 1'b0;
   logic [7:0] exp_q[$];

   always #2.5 clk = !clk;
   assign host_rd = mon_rd | tst_rd;

   bus_trace_enc i_bus_trace_enc (
      .clk(clk), .rst_n(rst_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
      .bus_rgn(bus_rgn), .host_rd(host_rd), .host_data(host_data),
      .host_valid(host_valid), .ovf_flag(ovf_flag)
   );

   function automatic logic [7:0] mk(input logic [1:0] rg, input bit r, input bit w, input int n);
      int c = n / 2;
      if (c > 7) c = 7;
      return {rg, r, w, n[0], c[2:0]};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: called on a negedge, returns on a negedge
   task automatic txn(input logic [1:0] rg, input bit r, input bit w, input int n,
                      input int gap, input bit keep);
      bus_rgn  = rg;
      bus_rd_n = !r;
      bus_wr_n = !w;
      repeat (n) begin
         @(negedge clk);
         bus_rgn = ~rg;   // R3: later region changes must not matter
      end
      bus_rd_n = 1'b1;
      bus_wr_n = 1'b1;
      if (keep) exp_q.push_back(mk(rg, r, w, n));
      repeat (gap) @(negedge clk);
   endtask

   // monitor: pops and compares while draining
   always @(negedge clk) begin
      mon_rd <= 1'b0;
      if (drain && host_valid) begin
         if (exp_q.size() == 0) chk("R2 R7 unexpected byte", host_data, 8'hxx);
         else chk("R3 R4 R5 R6 R7 byte", host_data, exp_q.pop_front());
         mon_rd <= 1'b1;
      end
   end

   task automatic wait_drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", {7'd0, host_valid}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", {7'd0, host_valid}, 8'd0);
      chk("R1 ovf after reset", {7'd0, ovf_flag}, 8'd0);

      // R2 timing, single read of DRAM lasting 3 samples
      bus_rgn = 2'b10; bus_rd_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 no byte while active", {7'd0, host_valid}, 8'd0);
      bus_rd_n = 1'b1;
      @(negedge clk);
      chk("R2 byte after release", {7'd0, host_valid}, 8'd1);
      chk("R3 R4 R5 R6 first byte", host_data, 8'b10_1_0_1_001);
      tst_rd = 1'b1; @(negedge clk); tst_rd = 1'b0;
      chk("R7 empty after read", {7'd0, host_valid}, 8'd0);

      // R7: reads on empty ignored
      tst_rd = 1'b1; repeat (2) @(negedge clk); tst_rd = 1'b0;
      chk("R7 empty read ignored", {7'd0, host_valid}, 8'd0);
      txn(2'b01, 1'b0, 1'b1, 4, 1, 1'b0);
      chk("R7 byte after empty reads", host_data, 8'b01_0_1_0_010);
      tst_rd = 1'b1; @(negedge clk); tst_rd = 1'b0;

      // varied traffic through the scoreboard
      drain = 1'b1;
      for (int i = 0; i < 40; i++) begin
         logic [1:0] rg = i[1:0];
         int k = (i / 4) % 3;
         txn(rg, k != 1, k != 0, 1 + (i % 20), 1 + (i % 3), 1'b1);
      end
      wait_drain();
      chk("R2 all bytes drained", {7'd0, host_valid}, 8'd0);
      chk("R8 no overflow yet", {7'd0, ovf_flag}, 8'd0);

      // R8: fill past depth with no draining
      drain = 1'b0;
      for (int i = 0; i < 18; i++)
         txn(2'b11, 1'b1, 1'b0, 2 + (i % 2), 1, i < 16);
      chk("R8 overflow flag set", {7'd0, ovf_flag}, 8'd1);
      drain = 1'b1;
      wait_drain();
      chk("R8 dropped bytes absent", {7'd0, host_valid}, 8'd0);
      chk("R8 overflow sticky", {7'd0, ovf_flag}, 8'd1);

      // long write, saturated count (R6)
      txn(2'b00, 1'b0, 1'b1, 25, 2, 1'b1);
      wait_drain();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule